// File: doc/BRIEF.md
# Low-Power Wake Qualifier

This block decides when a sleeping processor core should wake. It holds the current power mode. Mode 0 is active, and modes 1, 2 and 3 are progressively deeper sleep states. It accepts a sleep request that names a target mode. It watches a vector of level-sensitive peripheral request lines. When a request is qualified, it drives a one-cycle wake pulse and returns the mode to active. The per-source enables and the 3-bit per-source priority fields are written through plain write ports.

A source qualifies when three conditions hold:
- its request line is high;
- its enable bit is set;
- the current sleep depth allows it to wake the core.

If a handler was running when sleep began, one more condition applies: the source's priority field must be numerically greater than the priority of that handler. The handler flag and the handler priority are captured on entry to sleep and cleared on wake. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, the power mode is 0, the wake pulse is low, every enable is cleared and every priority field is 0. With all enables cleared, no request line can wake the core.
- R2: A sleep request with a non-zero target is accepted only in mode 0, and the mode becomes the target on the next clock edge. A request whose target is 0 leaves the mode at 0.
- R3: In mode 1, any enabled source at positions 0–3, 5–6, 8–10 or 13–19 wakes the core when its request line is high.
- R4: In mode 2 or mode 3, only positions 0, 1, 2, 3, 5, 6, 8, 9 and 10 can wake the core. Positions 13–19 are ignored at these depths.
- R5: Positions 4, 7, 11 and 12 never wake the core, whatever the mode.
- R6: A source wakes the core only while both its request line and its enable bit are high. Setting the enable while the request is already high causes a wake.
- R7: If sleep was entered with the handler flag set, only a source whose priority field is strictly greater than the captured handler priority can wake the core. An equal priority does not wake it.
- R8: A wake drives the wake pulse high for exactly one cycle. On the same edge, the mode becomes 0 and the captured handler state is cleared, so a later sleep without a handler is not gated.
- R9: A sleep request made while a source is already qualified for the target mode is refused, and the mode stays 0. A pending source that is not qualified for the target mode does not block the request.
- R10: A sleep request made while the core is already asleep is ignored, and the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lvl | input | N_SRC | Level-sensitive peripheral request lines |
| en_we | input | 1 | Write strobe for the whole enable vector |
| en_wdata | input | N_SRC | New enable vector |
| prio_we | input | 1 | Write strobe for one priority field |
| prio_sel | input | SEL_W | Source index of the priority field being written |
| prio_wdata | input | PRIO_W | New priority value |
| sleep_req | input | 1 | Sleep request strobe |
| sleep_mode | input | 2 | Target power mode of the request |
| hdl_active | input | 1 | A handler is running at the time of the request |
| hdl_prio | input | PRIO_W | Priority of that handler |
| pwr_mode | output | 2 | Current power mode |
| wake | output | 1 | One-cycle wake pulse |

## Verification
A wrong eligibility table bit or a wrong enable bit shows up one clock edge after the matching request rises. The wake pulse either fails to appear or appears when it should not, and the mode either stays at its sleep value or falls to 0 at the wrong time. A handler state that is not cleared does not show up on the wake itself. It shows up only on a later sleep, when an otherwise valid lower-priority source fails to wake the core. The bench therefore runs sleep periods back to back, with and without a handler. A wrong block check shows up one edge after the sleep request, because the mode then enters sleep when it should have stayed at 0.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_LIGHT   = 2'd1,
    PM_DEEP    = 2'd2,
    PM_DEEPEST = 2'd3
  } pmode_e;

  localparam int unsigned DEF_N_SRC  = 20;
  localparam int unsigned DEF_PRIO_W = 3;
  // Sources able to end a light sleep: every position except 4, 7, 11 and 12.
  localparam logic [DEF_N_SRC-1:0] DEF_LIGHT_MASK = 20'hFE76F;
  // Sources able to end a deep sleep: positions 0-3, 5-6 and 8-10.
  localparam logic [DEF_N_SRC-1:0] DEF_DEEP_MASK  = 20'h0076F;
endpackage

// File: rtl/lpw_cfg_regs.sv
module lpw_cfg_regs #(
  parameter int unsigned N_SRC  = 20,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_we,
  input  logic [N_SRC-1:0]              en_wdata,
  input  logic                          prio_we,
  input  logic [SEL_W-1:0]              prio_sel,
  input  logic [PRIO_W-1:0]             prio_wdata,
  output logic [N_SRC-1:0]              en_q,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[i] <= '0;
      else if (prio_we && prio_sel == SEL_W'(i))
        prio_q[i] <= prio_wdata;
    end
  end
endmodule

// File: rtl/lpw_qualify.sv
module lpw_qualify #(
  parameter int unsigned N_SRC  = 20,
  parameter int unsigned PRIO_W = 3,
  parameter logic [N_SRC-1:0] LIGHT_MASK = '1,
  parameter logic [N_SRC-1:0] DEEP_MASK  = '1
) (
  input  logic [N_SRC-1:0]              irq_lvl,
  input  logic [N_SRC-1:0]              en_q,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_q,
  input  logic [1:0]                    depth,
  input  logic                          gate_act,
  input  logic [PRIO_W-1:0]             gate_prio,
  output logic                          any_hit
);
  import lpw_pkg::*;

  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] hit;

  always_comb begin
    unique case (pmode_e'(depth))
      PM_LIGHT:            elig = LIGHT_MASK;
      PM_DEEP, PM_DEEPEST: elig = DEEP_MASK;
      default:             elig = '0;
    endcase
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = irq_lvl[i] & en_q[i] & elig[i] &
                    (~gate_act | (prio_q[i] > gate_prio));
  end

  assign any_hit = |hit;
endmodule

// File: rtl/lpw_mode_fsm.sv
module lpw_mode_fsm #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic [1:0]        sleep_mode,
  input  logic              hdl_active,
  input  logic [PRIO_W-1:0] hdl_prio,
  input  logic              wake_hit,
  input  logic              block_hit,
  output logic [1:0]        mode_q,
  output logic              wake_q,
  output logic              sav_act,
  output logic [PRIO_W-1:0] sav_prio
);
  import lpw_pkg::*;

  logic asleep;
  logic enter;

  assign asleep = (pmode_e'(mode_q) != PM_ACTIVE);
  assign enter  = !asleep && sleep_req &&
                  (pmode_e'(sleep_mode) != PM_ACTIVE) && !block_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_ACTIVE;
      wake_q   <= 1'b0;
      sav_act  <= 1'b0;
      sav_prio <= '0;
    end else begin
      wake_q <= 1'b0;
      if (asleep && wake_hit) begin
        mode_q   <= PM_ACTIVE;
        wake_q   <= 1'b1;
        sav_act  <= 1'b0;
        sav_prio <= '0;
      end else if (enter) begin
        mode_q   <= sleep_mode;
        sav_act  <= hdl_active;
        sav_prio <= hdl_active ? hdl_prio : '0;
      end
    end
  end
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl #(
  parameter int unsigned N_SRC  = lpw_pkg::DEF_N_SRC,
  parameter int unsigned PRIO_W = lpw_pkg::DEF_PRIO_W,
  parameter logic [N_SRC-1:0] LIGHT_MASK = lpw_pkg::DEF_LIGHT_MASK,
  parameter logic [N_SRC-1:0] DEEP_MASK  = lpw_pkg::DEF_DEEP_MASK,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_lvl,
  input  logic              en_we,
  input  logic [N_SRC-1:0]  en_wdata,
  input  logic              prio_we,
  input  logic [SEL_W-1:0]  prio_sel,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              sleep_req,
  input  logic [1:0]        sleep_mode,
  input  logic              hdl_active,
  input  logic [PRIO_W-1:0] hdl_prio,
  output logic [1:0]        pwr_mode,
  output logic              wake
);
  logic [N_SRC-1:0]             en_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [1:0]                   mode_q;
  logic                         sav_act;
  logic [PRIO_W-1:0]            sav_prio;
  logic                         wake_hit;
  logic                         block_hit;

  lpw_cfg_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_wdata(en_wdata),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .en_q(en_q), .prio_q(prio_q)
  );

  // Qualification against the current sleep depth and the captured handler.
  lpw_qualify #(.N_SRC(N_SRC), .PRIO_W(PRIO_W),
                .LIGHT_MASK(LIGHT_MASK), .DEEP_MASK(DEEP_MASK)) u_wake_q (
    .irq_lvl(irq_lvl), .en_q(en_q), .prio_q(prio_q),
    .depth(mode_q), .gate_act(sav_act), .gate_prio(sav_prio),
    .any_hit(wake_hit)
  );

  // Pre-check of a sleep request against the requested depth and live handler.
  lpw_qualify #(.N_SRC(N_SRC), .PRIO_W(PRIO_W),
                .LIGHT_MASK(LIGHT_MASK), .DEEP_MASK(DEEP_MASK)) u_block_q (
    .irq_lvl(irq_lvl), .en_q(en_q), .prio_q(prio_q),
    .depth(sleep_mode), .gate_act(hdl_active), .gate_prio(hdl_prio),
    .any_hit(block_hit)
  );

  lpw_mode_fsm #(.PRIO_W(PRIO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sleep_req(sleep_req), .sleep_mode(sleep_mode),
    .hdl_active(hdl_active), .hdl_prio(hdl_prio),
    .wake_hit(wake_hit), .block_hit(block_hit),
    .mode_q(mode_q), .wake_q(wake), .sav_act(sav_act), .sav_prio(sav_prio)
  );

  assign pwr_mode = mode_q;
endmodule

// File: rtl/lpw_chk.sv
module lpw_chk #(
  parameter int unsigned N_SRC = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_lvl,
  input logic             sleep_req,
  input logic [1:0]       sleep_mode,
  input logic [1:0]       pwr_mode,
  input logic             wake
);
  // R2
  stay_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd0 && !sleep_req) |=> (pwr_mode == 2'd0));

  // R2
  enter_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'd0 && sleep_req && sleep_mode != 2'd0 && irq_lvl == '0)
      |=> (pwr_mode == $past(sleep_mode)));

  // R8
  wake_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (pwr_mode == 2'd0 && $past(pwr_mode) != 2'd0));

  // R8
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R10
  quiet_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0 && irq_lvl == '0) |=> (pwr_mode == $past(pwr_mode) && !wake));
endmodule

bind lp_wake_ctrl lpw_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl),
  .sleep_req(sleep_req), .sleep_mode(sleep_mode),
  .pwr_mode(pwr_mode), .wake(wake)
);

// File: tb/lp_wake_ctrl_tb.sv
module lp_wake_ctrl_tb;
  localparam int N = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_lvl = '0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic         prio_we = 1'b0;
  logic [4:0]   prio_sel = '0;
  logic [2:0]   prio_wdata = '0;
  logic         sleep_req = 1'b0;
  logic [1:0]   sleep_mode = '0;
  logic         hdl_active = 1'b0;
  logic [2:0]   hdl_prio = '0;
  logic [1:0]   pwr_mode;
  logic         wake;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  lp_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl),
    .en_we(en_we), .en_wdata(en_wdata),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .sleep_req(sleep_req), .sleep_mode(sleep_mode),
    .hdl_active(hdl_active), .hdl_prio(hdl_prio),
    .pwr_mode(pwr_mode), .wake(wake)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_en(input logic [N-1:0] v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic set_prio(input int idx, input int p);
    @(negedge clk); prio_we = 1'b1; prio_sel = 5'(idx); prio_wdata = 3'(p);
    @(negedge clk); prio_we = 1'b0;
  endtask

  task automatic go_sleep(input int m, input bit ha, input int hp,
                          input int exp_mode, input string tag);
    @(negedge clk);
    sleep_req = 1'b1; sleep_mode = 2'(m); hdl_active = ha; hdl_prio = 3'(hp);
    @(negedge clk);
    sleep_req = 1'b0; hdl_active = 1'b0; hdl_prio = '0;
    chk(pwr_mode == 2'(exp_mode), tag, pwr_mode, exp_mode);
    chk(wake == 1'b0, tag, wake, 0);
  endtask

  task automatic wake_by(input int src, input string tag);
    @(negedge clk); irq_lvl[src] = 1'b1;
    @(negedge clk);
    chk(wake == 1'b1, tag, wake, 1);
    chk(pwr_mode == 2'd0, tag, pwr_mode, 0);
    irq_lvl[src] = 1'b0;
    @(negedge clk);
    chk(wake == 1'b0, {tag, " pulse width"}, wake, 0);
  endtask

  task automatic hold_on(input logic [N-1:0] v, input int exp_mode, input string tag);
    @(negedge clk); irq_lvl = v;
    repeat (3) @(negedge clk);
    chk(pwr_mode == 2'(exp_mode) && wake == 1'b0, tag, pwr_mode, exp_mode);
    irq_lvl = '0;
  endtask

  task automatic t_reset;
    chk(pwr_mode == 2'd0, "R1 reset mode", pwr_mode, 0);
    chk(wake == 1'b0, "R1 reset wake", wake, 0);
    go_sleep(1, 1'b0, 0, 1, "R1 sleep with enables cleared");
    hold_on('1, 1, "R1 cleared enables block all sources");
    set_en('1);
    set_prio(0, 0);
    wake_by(0, "R1 wake after enable");
  endtask

  task automatic t_light;
    set_en('1);
    go_sleep(1, 1'b0, 0, 1, "R3 enter mode 1");
    wake_by(13, "R3 mode 1 source 13");
    go_sleep(1, 1'b0, 0, 1, "R3 enter mode 1");
    wake_by(19, "R3 mode 1 source 19");
    go_sleep(1, 1'b0, 0, 1, "R3 enter mode 1");
    wake_by(5, "R3 mode 1 source 5");
  endtask

  task automatic t_deep;
    for (int m = 2; m <= 3; m++) begin
      go_sleep(m, 1'b0, 0, m, "R4 enter deep mode");
      hold_on(20'hFE000, m, "R4 sources 13-19 ignored in deep mode");
      wake_by(10, "R4 deep wake by source 10");
      go_sleep(m, 1'b0, 0, m, "R4 enter deep mode");
      wake_by(8, "R4 deep wake by source 8");
    end
  endtask

  task automatic t_reserved;
    go_sleep(1, 1'b0, 0, 1, "R5 enter mode 1");
    hold_on(20'h01890, 1, "R5 reserved 4 7 11 12 ignored");
    wake_by(18, "R5 exit via source 18");
  endtask

  task automatic t_enable;
    set_en(~20'h00008);
    go_sleep(2, 1'b0, 0, 2, "R6 enter mode 2");
    hold_on(20'h00008, 2, "R6 request without enable ignored");
    @(negedge clk); irq_lvl[3] = 1'b1;
    set_en('1);
    @(negedge clk);
    chk(wake == 1'b1, "R6 enable set while request high", wake, 1);
    chk(pwr_mode == 2'd0, "R6 mode after wake", pwr_mode, 0);
    irq_lvl = '0;
    @(negedge clk);
  endtask

  task automatic t_handler;
    set_prio(1, 4);
    set_prio(2, 5);
    go_sleep(2, 1'b1, 4, 2, "R7 enter mode 2 in handler");
    hold_on(20'h00002, 2, "R7 equal priority ignored");
    wake_by(2, "R7 higher priority wakes");
    go_sleep(2, 1'b0, 0, 2, "R8 enter mode 2 without handler");
    wake_by(1, "R8 handler state cleared on wake");
  endtask

  task automatic t_block;
    @(negedge clk); irq_lvl[6] = 1'b1;
    go_sleep(3, 1'b0, 0, 0, "R9 pending source blocks sleep");
    irq_lvl = '0;
    @(negedge clk); irq_lvl[15] = 1'b1;
    go_sleep(2, 1'b0, 0, 2, "R9 source not valid for depth does not block");
    @(negedge clk);
    chk(pwr_mode == 2'd2 && wake == 1'b0, "R9 still asleep", pwr_mode, 2);
    irq_lvl = '0;
    wake_by(0, "R9 exit");
  endtask

  task automatic t_ignore;
    go_sleep(0, 1'b0, 0, 0, "R2 target 0 leaves active");
    go_sleep(1, 1'b0, 0, 1, "R2 enter mode 1");
    go_sleep(3, 1'b0, 0, 1, "R10 request while asleep ignored");
    wake_by(9, "R10 exit");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_light();
    t_deep();
    t_reserved();
    t_enable();
    t_handler();
    t_block();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule